// File: doc/BRIEF.md
# Prescaled Dual-Compare Interval Timer

This block is a single channel of a programmable interval timer that runs from the system clock. Software programs a 16-bit control register and two 16-bit compare registers through a small register port. A power-of-two prescaler produces count ticks. On each tick a counter advances toward whichever compare register the control word selects. When the counter reaches that value the channel has expired. It can raise a one-cycle interrupt request toward an interrupt controller. It then either starts the next period at once or halts.

Only the system clock is a valid count source. Any other source encoding, an invalid compare selection or a zero compare value leaves the channel idle. A stop bit freezes counting. Every write that touches the low byte of the control register reloads the channel and restarts the period from zero.

Top module: `tmr_interval_timer`

## Requirements
- R1: After reset the control register and both compare registers read 0, and `irqReq` is low.
- R2: Registers sit at byte offsets 0x00 (control), 0x04 (first compare) and 0x06 (second compare) within the channel window. Reads are combinational. A write updates only the bytes whose enable is set: `regByteEn[0]` covers bits 7:0 and `regByteEn[1]` covers bits 15:8.
- R3: A control write that includes the low byte starts a period. `irqReq` is high for one cycle after the clock edge that lies 2^p × C edges after the write edge. Here p is control bits 13:10 and C is the selected compare value.
- R4: The prescale exponent is limited to 8, so any p above 8 behaves as p = 8.
- R5: Control bits 5:4 select the compare value: 1 selects the first compare register, 2 selects the second, and 0 or 3 keep the channel idle.
- R6: A selected compare value of zero keeps the channel idle.
- R7: Control bits 15:14 select the count source. Only 0 (system clock) runs the channel; other values keep it idle.
- R8: While control bit 1 (stop) is set, counting is frozen. A later control write with the bit clear starts a full period from zero.
- R9: With control bit 7 set, the channel restarts after each expiry and expires every 2^p × C clocks. With it clear, the channel expires once and stays idle.
- R10: Control bit 2 gates the interrupt. With it clear, expiries raise no request.
- R11: A control write that includes the low byte restarts the period. Writes to the high byte alone and writes to the compare registers do not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Byte offset within the channel window |
| regByteEn | input | 2 | Byte enables for a write |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for `regAddr` |
| irqReq | output | 1 | One-cycle interrupt request on expiry |

## Verification
A restarting write lands on clock edge W. The counter and prescaler clear at W and begin advancing on the next edge. The expiry is registered at edge W + 2^p × C, so `irqReq` is seen in the half cycle after that edge. The driver records W as one past the cycle count when it presents the write. It queues each due cycle, and the monitor compares the cycle count at every falling edge where `irqReq` is high. Any request with an empty queue is a failure, which covers every idle, gated or frozen case. Register reads are combinational and are sampled shortly after the address changes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_W = 16;

  // Control word layout (fields decoded by the channel logic)
  typedef struct packed {
    logic [1:0] clkSrc;    // 15:14
    logic [3:0] prescExp;  // 13:10
    logic [1:0] rsvdA;     // 9:8
    logic       repeatEn;  // 7
    logic       rsvdB;     // 6
    logic [1:0] cmpSel;    // 5:4
    logic       rsvdC;     // 3
    logic       intEn;     // 2
    logic       stop;      // 1
    logic       rsvdD;     // 0
  } tmrCtrl_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic restart;
    logic advance;
    logic expire;
  } tmrStrb_t;
endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int PRESC_CAP = 8,
  parameter logic [4:0] CTRL_OFS = 5'h00,
  parameter logic [4:0] CMPA_OFS = 5'h04,
  parameter logic [4:0] CMPB_OFS = 5'h06
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [4:0]       regAddr,
  input  logic [1:0]       regByteEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  tmrStrb_t         strb,
  output tmrCtrl_t         ctrlQ,
  output logic [REG_W-1:0] cmpVal,
  output logic             ctrlLowWr,
  output logic             tick,
  output logic             match
);
  localparam int NBYTES  = REG_W / 8;
  localparam int PRESC_W = PRESC_CAP;

  logic [REG_W-1:0]   ctrlReg, cmpA, cmpB, cnt;
  logic [PRESC_W-1:0] prescCnt, prescMask;
  logic [3:0]         pEff;
  logic [REG_W-1:0]   byteMask;

  genvar gb;
  generate
    for (gb = 0; gb < NBYTES; gb++) begin : g_mask
      assign byteMask[gb*8 +: 8] = {8{regByteEn[gb]}};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      cmpA    <= '0;
      cmpB    <= '0;
    end else if (regWrEn) begin
      if (regAddr == CTRL_OFS) ctrlReg <= (ctrlReg & ~byteMask) | (regWrData & byteMask);
      if (regAddr == CMPA_OFS) cmpA    <= (cmpA & ~byteMask) | (regWrData & byteMask);
      if (regAddr == CMPB_OFS) cmpB    <= (cmpB & ~byteMask) | (regWrData & byteMask);
    end
  end

  always_comb begin
    unique case (regAddr)
      CTRL_OFS: regRdData = ctrlReg;
      CMPA_OFS: regRdData = cmpA;
      CMPB_OFS: regRdData = cmpB;
      default:  regRdData = '0;
    endcase
  end

  assign ctrlQ     = tmrCtrl_t'(ctrlReg);
  assign ctrlLowWr = regWrEn && (regAddr == CTRL_OFS) && regByteEn[0];
  assign cmpVal    = (ctrlQ.cmpSel == 2'd2) ? cmpB : cmpA;

  assign pEff      = (int'(ctrlQ.prescExp) > PRESC_CAP) ? 4'(PRESC_CAP) : ctrlQ.prescExp;
  assign prescMask = PRESC_W'((32'd1 << pEff) - 32'd1);
  assign tick      = ((prescCnt & prescMask) == prescMask);
  assign match     = ({1'b0, cnt} + 17'd1) == {1'b0, cmpVal};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescCnt <= '0;
      cnt      <= '0;
    end else if (strb.restart) begin
      prescCnt <= '0;
      cnt      <= '0;
    end else if (strb.advance) begin
      if (tick) begin
        prescCnt <= '0;
        cnt      <= strb.expire ? '0 : cnt + 1'b1;
      end else begin
        prescCnt <= prescCnt + 1'b1;
      end
    end
  end

  // R11
  restart_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> (cnt == '0 && prescCnt == '0));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && !strb.restart) |=> ($stable(cnt) && $stable(prescCnt)));

  // R3
  expire_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.expire && !strb.restart) |=> (cnt == '0));
endmodule

// File: rtl/tmr_control.sv
module tmr_control
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tmrCtrl_t         ctrlQ,
  input  logic [REG_W-1:0] cmpVal,
  input  logic             ctrlLowWr,
  input  logic             tick,
  input  logic             match,
  output tmrStrb_t         strb,
  output logic             irqReq
);
  logic armed, selOk, runOk;

  assign selOk = (ctrlQ.cmpSel == 2'd1) || (ctrlQ.cmpSel == 2'd2);
  assign runOk = armed && (ctrlQ.clkSrc == 2'd0) && !ctrlQ.stop &&
                 selOk && (cmpVal != '0);

  assign strb.restart = ctrlLowWr;
  assign strb.advance = runOk && !ctrlLowWr;
  assign strb.expire  = strb.advance && tick && match;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed  <= 1'b0;
      irqReq <= 1'b0;
    end else begin
      if (strb.restart)                          armed <= 1'b1;
      else if (strb.expire && !ctrlQ.repeatEn)   armed <= 1'b0;
      irqReq <= strb.expire && ctrlQ.intEn;
    end
  end

  // R9
  oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.expire && !ctrlQ.repeatEn) |=> !armed);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> $past(ctrlQ.intEn));
endmodule

// File: rtl/tmr_interval_timer.sv
module tmr_interval_timer
  import tmr_pkg::*;
#(
  parameter int PRESC_CAP = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [4:0]  regAddr,
  input  logic [1:0]  regByteEn,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  output logic        irqReq
);
  tmrStrb_t         strb;
  tmrCtrl_t         ctrlQ;
  logic [REG_W-1:0] cmpVal;
  logic             ctrlLowWr, tick, match;

  tmr_datapath #(.PRESC_CAP(PRESC_CAP)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regByteEn(regByteEn), .regWrData(regWrData), .regRdData(regRdData),
    .strb(strb), .ctrlQ(ctrlQ), .cmpVal(cmpVal), .ctrlLowWr(ctrlLowWr),
    .tick(tick), .match(match)
  );

  tmr_control u_ctl (
    .clk(clk), .rstN(rstN), .ctrlQ(ctrlQ), .cmpVal(cmpVal),
    .ctrlLowWr(ctrlLowWr), .tick(tick), .match(match),
    .strb(strb), .irqReq(irqReq)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> !irqReq);
endmodule

// File: tb/tb_tmr_interval_timer.sv
`timescale 1ns/1ps
module tb_tmr_interval_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [1:0]  regByteEn = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        irqReq;

  always #2 clk = ~clk;

  tmr_interval_timer dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regByteEn(regByteEn), .regWrData(regWrData), .regRdData(regRdData),
    .irqReq(irqReq)
  );

  typedef struct { int due; string tag; } exp_t;
  exp_t expQ[$];
  int cyc = 0, nChk = 0, nFail = 0, nStray = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each request
  always @(negedge clk) begin
    if (rstN && irqReq) begin
      if (expQ.size() == 0) begin
        nStray++;
        check(1'b0, "R5/R6/R7/R8/R9/R10", "unexpected irq cycle", cyc, -1);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(cyc == e.due, e.tag, "irq cycle", cyc, e.due);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [1:0] be,
                    input logic [15:0] d, output int edgeNo);
    @(negedge clk);
    regAddr = a; regByteEn = be; regWrData = d; regWrEn = 1'b1;
    edgeNo = cyc + 1;
    @(negedge clk);
    regWrEn = 1'b0; regByteEn = '0;
  endtask

  task automatic rdChk(input logic [4:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    check(regRdData == exp, tag, "read data", int'(regRdData), int'(exp));
  endtask

  task automatic expectAt(input int due, input string tag);
    expQ.push_back('{due, tag});
  endtask

  task automatic waitUntil(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic quiet(input int n, input string tag);
    int s;
    s = nStray;
    repeat (n) @(negedge clk);
    check(nStray == s, tag, "stray irqs", nStray - s, 0);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog actual=expired expected=done");
    finishRun();
  end

  initial begin
    int w, w2, x;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rdChk(5'h00, 16'h0000, "R1");
    rdChk(5'h04, 16'h0000, "R1");
    rdChk(5'h06, 16'h0000, "R1");
    check(irqReq == 1'b0, "R1", "irqReq", int'(irqReq), 0);

    // R2 registers and byte enables
    wr(5'h04, 2'b11, 16'h0005, x);
    rdChk(5'h04, 16'h0005, "R2");
    wr(5'h06, 2'b11, 16'h1203, x);
    wr(5'h06, 2'b01, 16'hFF07, x);
    rdChk(5'h06, 16'h1207, "R2");
    wr(5'h06, 2'b10, 16'h00AA, x);
    rdChk(5'h06, 16'h0007, "R2");
    wr(5'h06, 2'b11, 16'h0003, x);

    // R3 one-shot, p=2, first compare=5 -> 20 clocks
    wr(5'h00, 2'b11, 16'h0814, w);
    rdChk(5'h00, 16'h0814, "R2");
    expectAt(w + 20, "R3");
    waitUntil(w + 60);
    check(expQ.size() == 0, "R9", "pending after one-shot", expQ.size(), 0);

    // R4 p=12 capped to 8, R5 second compare=3 -> 768 clocks
    wr(5'h00, 2'b11, 16'h3024, w);
    expectAt(w + 768, "R4");
    waitUntil(w + 800);

    // R9 repeat, p=0, C=5
    wr(5'h00, 2'b11, 16'h0094, w);
    expectAt(w + 5, "R9"); expectAt(w + 10, "R9");
    expectAt(w + 15, "R9"); expectAt(w + 20, "R9");
    waitUntil(w + 21);
    wr(5'h00, 2'b11, 16'h0000, x);
    quiet(40, "R9");

    // R5 invalid selections
    wr(5'h00, 2'b11, 16'h0034, x);
    quiet(40, "R5");
    wr(5'h00, 2'b11, 16'h0004, x);
    quiet(40, "R5");

    // R6 zero compare
    wr(5'h04, 2'b11, 16'h0000, x);
    wr(5'h00, 2'b11, 16'h0014, x);
    quiet(40, "R6");
    wr(5'h00, 2'b11, 16'h0000, x);
    wr(5'h04, 2'b11, 16'h0005, x);

    // R7 non-system clock source
    wr(5'h00, 2'b11, 16'h4014, x);
    quiet(40, "R7");

    // R10 interrupt disabled, repeating
    wr(5'h00, 2'b11, 16'h0090, x);
    quiet(40, "R10");

    // R8 stop then resume
    wr(5'h00, 2'b11, 16'h0016, x);
    quiet(30, "R8");
    wr(5'h00, 2'b11, 16'h0014, w);
    expectAt(w + 5, "R8");
    waitUntil(w + 15);

    // R11 restart by low-byte write
    wr(5'h00, 2'b11, 16'h0814, w);
    repeat (10) @(negedge clk);
    wr(5'h00, 2'b01, 16'h0014, w2);
    expectAt(w2 + 20, "R11");
    waitUntil(w2 + 40);

    // R11 high-byte and compare writes do not restart
    wr(5'h00, 2'b11, 16'h0814, w);
    repeat (4) @(negedge clk);
    wr(5'h00, 2'b10, 16'h0800, x);
    wr(5'h06, 2'b11, 16'h0009, x);
    expectAt(w + 20, "R11");
    waitUntil(w + 50);

    check(expQ.size() == 0, "R3", "missed irqs", expQ.size(), 0);
    finishRun();
  end
endmodule